// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Sequencer

This block drives the slot index of a short instruction block (up to 16 addressable slots, 14 in typical use) so that loop bodies repeat without any branch instruction being issued. The host writes, for each of up to six nesting levels, a first slot, a last slot and a pass count, and chooses how many levels are in use. After a start pulse the block emits one slot index per cycle. It counts passes at loop ends, steps outward when an inner loop is used up, and reloads an inner loop each time it is entered again.

Two runtime condition inputs stand in for results from execution. One leaves a chosen active level at once and resumes after that level's last slot. The other transfers control to the start of a chosen enclosing level and drops every deeper level. No register hazard checking takes place: keeping data from overlapping inside a body is up to software.

Top module: `zol_nest_ctrl`

## Requirements
- R1: After reset, `issue_valid`, `done` and `active_depth` are all 0.
- R2: When idle, a `go` pulse makes the block issue slot 0 on the next cycle, then one slot per cycle. `go` has no effect while a run is in progress.
- R3: When no loop action applies, the next slot is the current slot plus one.
- R4: A level is entered when the issued slot equals its first slot, its index equals the current active depth, and it is below `nest_depth`. Entering loads its programmed count. Several nested levels that share a first slot are entered in the same cycle.
- R5: When the issued slot is the last slot of the deepest active level and that level has more than one pass left, one pass is taken off and the next slot is the level's first slot. A count of N gives N passes, and a count of 0 acts as 1.
- R6: When the deepest active level has its last pass at its last slot, it is left. Any enclosing level with the same last slot is handled in the same cycle. A level that is left is reloaded on its next entry.
- R7: `cond_exit` with `exit_lvl` below the active depth (including levels entered this cycle) leaves that level and all deeper ones. The next slot is that level's last slot plus one. `cond_exit` takes precedence over `cond_jump`.
- R8: `cond_jump` with `jump_lvl` below the active depth drops all deeper levels. The next slot is the first slot of the target level, and that level's remaining pass count is unchanged.
- R9: `cond_exit` or `cond_jump` that names a level at or beyond the active depth is ignored.
- R10: When level 0 is left, by using up its count or by an exit, `done` is high for exactly one cycle, and `issue_valid` is low in that cycle.
- R11: Six levels and 16-bit counts are supported; the active depth never exceeds the level count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one level's settings |
| cfg_lvl | input | 3 | Level written |
| cfg_start | input | 4 | First slot of the level |
| cfg_end | input | 4 | Last slot of the level |
| cfg_count | input | 16 | Passes of the level |
| nest_depth | input | 3 | Number of levels in use |
| go | input | 1 | Start a run |
| cond_exit | input | 1 | Early exit request |
| exit_lvl | input | 3 | Level to leave |
| cond_jump | input | 1 | Jump request |
| jump_lvl | input | 3 | Level to jump to |
| issue_valid | output | 1 | A slot is issued this cycle |
| issue_slot | output | 4 | Slot index issued |
| done | output | 1 | Outermost loop has finished |
| active_depth | output | 3 | Number of levels currently active |

## Verification
The sequencer is tested with a single loop, two nested loops, three levels that share first and last slots, a single-slot loop with a large count, a zero count, and a full six-deep nest. Together these tell apart errors in entry, in pass counting and in stepping outward. The exit and jump inputs are raised on chosen cycles, including the cycle a level is entered, both together, and with an inactive level named. This separates the precedence rule, the discarding of deeper levels, and the ignore rule. A behavioural stack model predicts slot, depth and done every cycle, and the total issued cycles per run are also checked against counts worked out by hand.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int unsigned ZOL_LEVELS  = 6;
  localparam int unsigned ZOL_SLOT_W  = 4;
  localparam int unsigned ZOL_COUNT_W = 16;

  typedef enum logic [2:0] {
    STEP_IDLE,
    STEP_SEQ,
    STEP_LOOP,
    STEP_EXIT,
    STEP_JUMP
  } step_e;
endpackage

// File: rtl/zol_cfg_bank.sv
module zol_cfg_bank #(
  parameter int unsigned NLVL    = 6,
  parameter int unsigned SLOT_W  = 4,
  parameter int unsigned COUNT_W = 16,
  localparam int unsigned LVL_W  = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LVL_W-1:0]   wr_lvl,
  input  logic [SLOT_W-1:0]  wr_first,
  input  logic [SLOT_W-1:0]  wr_last,
  input  logic [COUNT_W-1:0] wr_count,
  output logic [SLOT_W-1:0]  first_o [NLVL],
  output logic [SLOT_W-1:0]  last_o  [NLVL],
  output logic [COUNT_W-1:0] count_o [NLVL]
);
  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    logic sel;
    assign sel = we && (wr_lvl == LVL_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        first_o[g] <= '0;
        last_o[g]  <= '0;
        count_o[g] <= '0;
      end else if (sel) begin
        first_o[g] <= wr_first;
        last_o[g]  <= wr_last;
        count_o[g] <= wr_count;
      end
    end
  end
endmodule

// File: rtl/zol_pass_counters.sv
module zol_pass_counters #(
  parameter int unsigned NLVL    = 6,
  parameter int unsigned COUNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NLVL-1:0]    wr_en,
  input  logic [COUNT_W-1:0] wr_val [NLVL],
  output logic [COUNT_W-1:0] left_o [NLVL]
);
  for (genvar g = 0; g < NLVL; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n)        left_o[g] <= '0;
      else if (wr_en[g]) left_o[g] <= wr_val[g];
    end
  end
endmodule

// File: rtl/zol_nest_ctrl.sv
module zol_nest_ctrl #(
  parameter int unsigned NLVL    = zol_pkg::ZOL_LEVELS,
  parameter int unsigned SLOT_W  = zol_pkg::ZOL_SLOT_W,
  parameter int unsigned COUNT_W = zol_pkg::ZOL_COUNT_W,
  localparam int unsigned LVL_W  = (NLVL > 1) ? $clog2(NLVL) : 1,
  localparam int unsigned DEP_W  = $clog2(NLVL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [LVL_W-1:0]   cfg_lvl,
  input  logic [SLOT_W-1:0]  cfg_start,
  input  logic [SLOT_W-1:0]  cfg_end,
  input  logic [COUNT_W-1:0] cfg_count,
  input  logic [DEP_W-1:0]   nest_depth,
  input  logic               go,
  input  logic               cond_exit,
  input  logic [LVL_W-1:0]   exit_lvl,
  input  logic               cond_jump,
  input  logic [LVL_W-1:0]   jump_lvl,
  output logic               issue_valid,
  output logic [SLOT_W-1:0]  issue_slot,
  output logic               done,
  output logic [DEP_W-1:0]   active_depth
);
  import zol_pkg::*;

  function automatic logic [COUNT_W-1:0] pass_total(input logic [COUNT_W-1:0] c);
    return (c == '0) ? COUNT_W'(1) : c;
  endfunction

  function automatic logic [SLOT_W-1:0] slot_after(input logic [SLOT_W-1:0] s);
    return s + 1'b1;
  endfunction

  logic [SLOT_W-1:0]  lvl_first [NLVL];
  logic [SLOT_W-1:0]  lvl_last  [NLVL];
  logic [COUNT_W-1:0] lvl_count [NLVL];
  logic [COUNT_W-1:0] lvl_left  [NLVL];
  logic [COUNT_W-1:0] eff_left  [NLVL];
  logic [COUNT_W-1:0] left_val  [NLVL];
  logic [NLVL-1:0]    left_wr;

  zol_cfg_bank #(.NLVL(NLVL), .SLOT_W(SLOT_W), .COUNT_W(COUNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wr_lvl(cfg_lvl),
    .wr_first(cfg_start), .wr_last(cfg_end), .wr_count(cfg_count),
    .first_o(lvl_first), .last_o(lvl_last), .count_o(lvl_count)
  );

  zol_pass_counters #(.NLVL(NLVL), .COUNT_W(COUNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr_en(left_wr), .wr_val(left_val),
    .left_o(lvl_left)
  );

  logic              run_q, run_n;
  logic              done_q, done_n;
  logic [SLOT_W-1:0] pc_q, pc_n;
  logic [DEP_W-1:0]  dep_q, dep_n;
  logic [DEP_W-1:0]  ent_d, out_d;
  logic [LVL_W-1:0]  loop_lvl;
  logic [SLOT_W-1:0] loop_target;
  logic              loop_hit, scan_stop;
  logic              exit_ok, jump_ok;
  step_e             step;

  // named events for the checks
  logic loop_take, exit_take, jump_take;
  assign loop_take = (step == STEP_LOOP);
  assign exit_take = (step == STEP_EXIT);
  assign jump_take = (step == STEP_JUMP);

  // entry of nested levels at the current slot
  always_comb begin
    ent_d = dep_q;
    for (int k = 0; k < NLVL; k++) begin
      if (run_q && int'(ent_d) == k && k < int'(nest_depth) &&
          lvl_first[k] == pc_q)
        ent_d = DEP_W'(k + 1);
    end
  end

  // remaining passes as seen this cycle, loading entered levels
  always_comb begin
    for (int k = 0; k < NLVL; k++)
      eff_left[k] = (k >= int'(dep_q)) ? pass_total(lvl_count[k]) : lvl_left[k];
  end

  // innermost-first scan of levels ending at this slot
  always_comb begin
    loop_hit  = 1'b0;
    scan_stop = 1'b0;
    loop_lvl  = '0;
    out_d     = ent_d;
    for (int k = NLVL - 1; k >= 0; k--) begin
      if (!scan_stop && k < int'(ent_d)) begin
        if (lvl_last[k] == pc_q) begin
          if (eff_left[k] > COUNT_W'(1)) begin
            loop_hit  = 1'b1;
            loop_lvl  = LVL_W'(k);
            scan_stop = 1'b1;
          end else begin
            out_d = DEP_W'(k);
          end
        end else begin
          scan_stop = 1'b1;
        end
      end
    end
    loop_target = lvl_first[loop_lvl];
  end

  assign exit_ok = cond_exit && (DEP_W'(exit_lvl) < ent_d);
  assign jump_ok = cond_jump && (DEP_W'(jump_lvl) < ent_d);

  always_comb begin
    run_n    = run_q;
    done_n   = 1'b0;
    pc_n     = pc_q;
    dep_n    = dep_q;
    step     = STEP_IDLE;
    left_wr  = '0;
    left_val = eff_left;
    for (int k = 0; k < NLVL; k++)
      if (k >= int'(dep_q) && k < int'(ent_d)) left_wr[k] = 1'b1;

    if (!run_q) begin
      if (go) begin
        run_n = 1'b1;
        pc_n  = '0;
        dep_n = '0;
      end
    end else if (exit_ok) begin
      step  = STEP_EXIT;
      dep_n = DEP_W'(exit_lvl);
      pc_n  = slot_after(lvl_last[exit_lvl]);
      if (exit_lvl == '0) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end else if (jump_ok) begin
      step  = STEP_JUMP;
      dep_n = DEP_W'(jump_lvl) + DEP_W'(1);
      pc_n  = lvl_first[jump_lvl];
    end else if (loop_hit) begin
      step               = STEP_LOOP;
      dep_n              = DEP_W'(loop_lvl) + DEP_W'(1);
      pc_n               = loop_target;
      left_wr[loop_lvl]  = 1'b1;
      left_val[loop_lvl] = eff_left[loop_lvl] - COUNT_W'(1);
    end else begin
      step  = STEP_SEQ;
      dep_n = out_d;
      pc_n  = slot_after(pc_q);
      if (ent_d != '0 && out_d == '0) begin
        run_n  = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      pc_q   <= '0;
      dep_q  <= '0;
    end else begin
      run_q  <= run_n;
      done_q <= done_n;
      pc_q   <= pc_n;
      dep_q  <= dep_n;
    end
  end

  assign issue_valid  = run_q;
  assign issue_slot   = pc_q;
  assign done         = done_q;
  assign active_depth = dep_q;

  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(active_depth) <= NLVL);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !issue_valid);
  assert_loop_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_take |=> issue_slot == $past(loop_target));
  assert_exit_depth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exit_take |=> active_depth == DEP_W'($past(exit_lvl)));
  assert_jump_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_take |=> active_depth == DEP_W'($past(jump_lvl)) + DEP_W'(1));
endmodule

// File: tb/zol_nest_ctrl_test.sv
module zol_nest_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_lvl = '0;
  logic [3:0]  cfg_start = '0, cfg_end = '0;
  logic [15:0] cfg_count = '0;
  logic [2:0]  nest_depth = '0;
  logic        go = 1'b0;
  logic        cond_exit = 1'b0, cond_jump = 1'b0;
  logic [2:0]  exit_lvl = '0, jump_lvl = '0;
  logic        issue_valid, done;
  logic [3:0]  issue_slot;
  logic [2:0]  active_depth;

  always #(CLK_PERIOD/2) clk = ~clk;

  zol_nest_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lvl(cfg_lvl),
    .cfg_start(cfg_start), .cfg_end(cfg_end), .cfg_count(cfg_count),
    .nest_depth(nest_depth), .go(go), .cond_exit(cond_exit),
    .exit_lvl(exit_lvl), .cond_jump(cond_jump), .jump_lvl(jump_lvl),
    .issue_valid(issue_valid), .issue_slot(issue_slot), .done(done),
    .active_depth(active_depth)
  );

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  // reference model: stack of remaining passes, one entry per active level
  int m_first [NL];
  int m_last  [NL];
  int m_cnt   [NL];
  int stk[$];
  int m_pc = 0;
  bit m_run = 0, m_done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_pc = 0; stk.delete();
    end else if (!m_run) begin
      m_done = 0;
      if (go) begin m_run = 1; m_pc = 0; stk.delete(); end
    end else begin
      bit handled;
      m_done = 0;
      while (stk.size() < int'(nest_depth) && stk.size() < NL &&
             m_first[stk.size()] == m_pc)
        stk.push_back(m_cnt[stk.size()] == 0 ? 1 : m_cnt[stk.size()]);
      if (cond_exit && int'(exit_lvl) < stk.size()) begin
        int lv = int'(exit_lvl);
        while (stk.size() > lv) void'(stk.pop_back());
        m_pc = (m_last[lv] + 1) % 16;
        if (lv == 0) begin m_run = 0; m_done = 1; end
      end else if (cond_jump && int'(jump_lvl) < stk.size()) begin
        while (stk.size() > int'(jump_lvl) + 1) void'(stk.pop_back());
        m_pc = m_first[int'(jump_lvl)];
      end else begin
        handled = 0;
        while (!handled && stk.size() > 0 && m_last[stk.size()-1] == m_pc) begin
          if (stk[$] > 1) begin
            stk[$] = stk[$] - 1;
            m_pc = m_first[stk.size()-1];
            handled = 1;
          end else begin
            void'(stk.pop_back());
            if (stk.size() == 0) begin m_run = 0; m_done = 1; end
          end
        end
        if (!handled) m_pc = (m_pc + 1) % 16;
      end
    end
    if (rst_n && cfg_we && int'(cfg_lvl) < NL) begin
      m_first[cfg_lvl] = int'(cfg_start);
      m_last[cfg_lvl]  = int'(cfg_end);
      m_cnt[cfg_lvl]   = int'(cfg_count);
    end
  endtask

  task automatic compare();
    check(issue_valid == m_run, cur_req, int'(issue_valid), int'(m_run));
    check(done == m_done, cur_req, int'(done), int'(m_done));
    check(int'(active_depth) == (m_run ? stk.size() : 0), cur_req,
          int'(active_depth), m_run ? stk.size() : 0);
    if (m_run) check(int'(issue_slot) == m_pc, cur_req, int'(issue_slot), m_pc);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic set_lvl(input int l, input int s, input int e, input int c);
    cfg_we = 1; cfg_lvl = 3'(l); cfg_start = 4'(s); cfg_end = 4'(e); cfg_count = 16'(c);
    tick();
    cfg_we = 0;
  endtask

  // runs until done; exit/jump are raised on the given issue index
  task automatic run(input int ex_at, input int ex_l, input int jp_at, input int jp_l,
                     input bit hold_go, output int issued);
    issued = 0;
    go = 1;
    tick();
    go = hold_go;
    for (int i = 0; i < 5000; i++) begin
      if (issue_valid) issued++;
      cond_exit = (i == ex_at); exit_lvl = 3'(ex_l);
      cond_jump = (i == jp_at); jump_lvl = 3'(jp_l);
      tick();
      if (done) break;
    end
    cond_exit = 0; cond_jump = 0; go = 0;
    tick();
  endtask

  task automatic prog_two();
    nest_depth = 3'd2;
    set_lvl(0, 1, 5, 2);
    set_lvl(1, 2, 3, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_bad++; n_cmp++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    @(negedge clk);
    tick(); tick();
    cur_req = "R1";
    check(issue_valid == 0 && done == 0 && active_depth == 0, "R1",
          int'(issue_valid) + int'(done) + int'(active_depth), 0);
    rst_n = 1;
    tick();

    // R2 R3 R5: single level, go held high during the run is ignored
    cur_req = "R5";
    nest_depth = 3'd1;
    set_lvl(0, 2, 4, 3);
    run(-1, 0, -1, 0, 1'b1, n);
    check(n == 11, "R2", n, 11);

    // R4 R6: two nested levels
    cur_req = "R6";
    prog_two();
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 19, "R6", n, 19);

    // R4: shared first and last slots across three levels
    cur_req = "R4";
    nest_depth = 3'd3;
    set_lvl(0, 0, 4, 2);
    set_lvl(1, 0, 2, 2);
    set_lvl(2, 2, 2, 3);
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 24, "R4", n, 24);

    // R5: zero count acts as one pass
    cur_req = "R5";
    nest_depth = 3'd1;
    set_lvl(0, 0, 1, 0);
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 2, "R5", n, 2);

    // R11: large count single-slot loop
    cur_req = "R11";
    set_lvl(0, 0, 0, 1000);
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 1000, "R11", n, 1000);

    // R11: six-deep nest
    nest_depth = 3'd6;
    for (int k = 0; k < 6; k++) set_lvl(k, k, 13 - k, 2);
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 380, "R11", n, 380);

    // R7: exit inner level mid-body, and on its entry cycle
    cur_req = "R7";
    prog_two();
    run(3, 1, -1, 0, 1'b0, n);
    check(n == 15, "R7", n, 15);
    run(2, 1, -1, 0, 1'b0, n);
    check(n == 14, "R7", n, 14);

    // R8: jump from inner level to outer level start
    cur_req = "R8";
    run(-1, 0, 4, 0, 1'b0, n);
    check(n == 23, "R8", n, 23);

    // R9: requests naming inactive levels
    cur_req = "R9";
    run(3, 5, 5, 3, 1'b0, n);
    check(n == 19, "R9", n, 19);

    // R10: exit on outermost level, with a jump in the same cycle (R7 precedence)
    cur_req = "R10";
    run(6, 0, 6, 0, 1'b0, n);
    check(n == 7, "R10", n, 7);
    check(issue_valid == 0 && done == 0, "R10", int'(issue_valid) + int'(done), 0);

    // R3: straight-line slots before a loop
    cur_req = "R3";
    nest_depth = 3'd1;
    set_lvl(0, 5, 5, 1);
    run(-1, 0, -1, 0, 1'b0, n);
    check(n == 6, "R3", n, 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule